// File: doc/BRIEF.md
# Memory-Stage Serial Bit Delay Line

This block delays a one-bit serial stream by a long, fixed number of bit periods without a long register chain. The storage is a cascade of small single-port memory stages that share one address counter. Each bit period runs a short phase sequence. First every stage reads the old bit held at the current address into its read latch. Then every stage writes its incoming bit into that same location, and the counter steps to the next address.

The first stage takes its incoming bit from the chain input. Each later stage takes the bit that the stage before it has just read. A bit written at some address is read back when the counter next returns to that address, one full counter cycle later. It then moves on to the next stage. With `NUM_STAGES` stages of `STAGE_DEPTH` locations each, a bit reaches the output after N = `NUM_STAGES` * `STAGE_DEPTH` bit periods.

A bit period starts when `bitEn` is sampled high while the sequencer is idle. Reset clears every memory location, all latches and the counter.

Top module: `ramShiftDelay`

## Requirements
- R1: After reset `serOut` is 0, and it stays 0 for the first N bit periods, where N = `NUM_STAGES` * `STAGE_DEPTH`.
- R2: One shared address counter steps by exactly one per bit period and wraps from `STAGE_DEPTH`-1 to 0. It does not have to be a power of two. It holds its value between bit periods.
- R3: The value of `serOut` after bit period m equals the `serIn` bit captured in bit period m-N.
- R4: Within a bit period the read strobe comes in the clock cycle before the write strobe. The two strobes are never active in the same cycle.
- R5: A bit period starts on the clock edge where `bitEn` is sampled high while idle, and `serIn` is captured on that edge. `serOut` keeps its old value through the following edge and takes its new value on the second edge after the capture edge.
- R6: `bitEn` has no effect while a bit period is in progress. Holding it high for the three cycles of one period produces exactly one bit period.
- R7: While `bitEn` is low and no bit period is in progress, `serOut` and the address counter stay unchanged, whatever `serIn` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all phases run on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Bit clock enable; starts one bit period when sampled high while idle |
| serIn | input | 1 | Serial data input, captured at the start of a bit period |
| serOut | output | 1 | Serial data output, delayed by N bit periods |

## Verification
The assertions check the phase ordering and the counter on every cycle. The read strobe always precedes the write strobe and the two never coincide. A capture is always followed by a read. The counter advances by one with wrap only on a write phase, and `serOut` moves only on a write phase. Only the bench scenarios can show the end-to-end delay of exactly N periods, the zero output during the first N periods, the wrap at a depth that is not a power of two, and the harmlessness of a held `bitEn` or of `serIn` toggling outside the capture edge. These are observed through the ports against a history model.

// File: rtl/ramShiftPkg.sv
package ramShiftPkg;

  typedef struct packed {
    logic capStb;
    logic rdStb;
    logic wrStb;
  } seqStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } seqPhase_t;

endpackage

// File: rtl/ramShiftCtrl.sv
module ramShiftCtrl
  import ramShiftPkg::*;
#(
  parameter int STAGE_DEPTH = 16,
  parameter int ADDR_W      = $clog2(STAGE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  output seqStrobes_t       strb,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(STAGE_DEPTH - 1);

  seqPhase_t phase;
  seqPhase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (bitEn) phaseNext = PH_READ;
      PH_READ:  phaseNext = PH_WRITE;
      PH_WRITE: phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    strb.capStb = (phase == PH_IDLE) && bitEn;
    strb.rdStb  = (phase == PH_READ);
    strb.wrStb  = (phase == PH_WRITE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      addr  <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == PH_WRITE) begin
        addr <= (addr == LAST_ADDR) ? '0 : addr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ramShiftStage.sv
module ramShiftStage #(
  parameter int STAGE_DEPTH = 16,
  parameter int ADDR_W      = $clog2(STAGE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit,
  output logic              rdBit
);

  logic memArr [STAGE_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGE_DEPTH; i++) begin
        memArr[i] <= 1'b0;
      end
      rdBit <= 1'b0;
    end else begin
      if (rdStb) begin
        rdBit <= memArr[addr];
      end
      if (wrStb) begin
        memArr[addr] <= wrBit;
      end
    end
  end

endmodule

// File: rtl/ramShiftData.sv
module ramShiftData
  import ramShiftPkg::*;
#(
  parameter int NUM_STAGES  = 4,
  parameter int STAGE_DEPTH = 16,
  parameter int ADDR_W      = $clog2(STAGE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              serIn,
  output logic              serOut
);

  logic inBit;
  logic [NUM_STAGES-1:0] wrBits;
  logic [NUM_STAGES-1:0] rdBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBit <= 1'b0;
    end else if (strb.capStb) begin
      inBit <= serIn;
    end
  end

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign wrBits[k] = inBit;
    end else begin : g_link
      assign wrBits[k] = rdBits[k-1];
    end

    ramShiftStage #(
      .STAGE_DEPTH(STAGE_DEPTH),
      .ADDR_W     (ADDR_W)
    ) stage_i (
      .clk  (clk),
      .rstN (rstN),
      .rdStb(strb.rdStb),
      .wrStb(strb.wrStb),
      .addr (addr),
      .wrBit(wrBits[k]),
      .rdBit(rdBits[k])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut <= 1'b0;
    end else if (strb.wrStb) begin
      serOut <= rdBits[NUM_STAGES-1];
    end
  end

endmodule

// File: rtl/ramShiftDelay.sv
module ramShiftDelay
  import ramShiftPkg::*;
#(
  parameter int NUM_STAGES  = 4,
  parameter int STAGE_DEPTH = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic serIn,
  output logic serOut
);

  localparam int ADDR_W = (STAGE_DEPTH > 1) ? $clog2(STAGE_DEPTH) : 1;

  seqStrobes_t       seqStb;
  logic [ADDR_W-1:0] stepAddr;

  ramShiftCtrl #(
    .STAGE_DEPTH(STAGE_DEPTH),
    .ADDR_W     (ADDR_W)
  ) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .bitEn(bitEn),
    .strb (seqStb),
    .addr (stepAddr)
  );

  ramShiftData #(
    .NUM_STAGES (NUM_STAGES),
    .STAGE_DEPTH(STAGE_DEPTH),
    .ADDR_W     (ADDR_W)
  ) data_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (seqStb),
    .addr  (stepAddr),
    .serIn (serIn),
    .serOut(serOut)
  );

endmodule

// File: rtl/ramShiftChk.sv
module ramShiftChk
  import ramShiftPkg::*;
#(
  parameter int STAGE_DEPTH = 16,
  parameter int ADDR_W      = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              serOut,
  input seqStrobes_t       strb,
  input logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(STAGE_DEPTH - 1);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdStb && strb.wrStb)); // R4

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |-> $past(strb.rdStb)); // R4

  AST_CAPTURE_THEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.capStb |=> strb.rdStb); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |=> (addr == (($past(addr) == LAST_ADDR) ? '0 : $past(addr) + 1'b1))); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStb |=> $stable(addr)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStb |=> $stable(serOut)); // R5

endmodule

bind ramShiftDelay ramShiftChk #(
  .STAGE_DEPTH(STAGE_DEPTH),
  .ADDR_W     (ADDR_W)
) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .serOut(serOut),
  .strb  (seqStb),
  .addr  (stepAddr)
);

// File: tb/ramShiftDelay_tb_top.sv
`timescale 1ns/1ps
module ramShiftDelay_tb_top;

  localparam int NUM_STAGES  = 3;
  localparam int STAGE_DEPTH = 10;
  localparam int TOTAL       = NUM_STAGES * STAGE_DEPTH;
  localparam int MAX_STEPS   = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic serIn = 1'b0;
  logic serOut;

  int nCompared = 0;
  int nMismatched = 0;
  int stepCnt = 0;
  bit histBits [MAX_STEPS];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ramShiftDelay #(
    .NUM_STAGES (NUM_STAGES),
    .STAGE_DEPTH(STAGE_DEPTH)
  ) dut_i (
    .clk   (clk),
    .rstN  (rstN),
    .bitEn (bitEn),
    .serIn (serIn),
    .serOut(serOut)
  );

  function automatic logic expOut(int m);
    if (m < TOTAL) return 1'b0;
    return histBits[m - TOTAL];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: serOut actual=%b expected=%b (step %0d, t=%0t)",
               req, act, exp, stepCnt, $time);
    end
  endtask

  // hold = 1: bitEn high for the capture edge only; hold = 3: high for the whole period
  task automatic doStep(input logic b, input int hold);
    logic prevOut;
    logic expNow;
    @(negedge clk);
    prevOut = serOut;
    bitEn = 1'b1;
    serIn = b;
    histBits[stepCnt] = b;
    expNow = expOut(stepCnt);
    @(negedge clk);                 // capture edge passed
    serIn = ~b;                     // R5: later serIn changes must not matter
    if (hold < 2) bitEn = 1'b0;
    @(negedge clk);                 // read edge passed
    check("R5 hold before write", serOut, prevOut);
    if (hold < 3) bitEn = 1'b0;
    @(negedge clk);                 // write edge passed
    bitEn = 1'b0;
    if (stepCnt < TOTAL) check("R1 zero during fill", serOut, expNow);
    else if (hold == 3) check("R6 held enable one period", serOut, expNow);
    else check("R3 R2 delay of N periods", serOut, expNow);
    stepCnt++;
  endtask

  task automatic idleGap(input int cycles);
    logic prevOut;
    prevOut = serOut;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      serIn = 1'($urandom);
      check("R7 idle hold", serOut, prevOut);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 reset value", serOut, 1'b0);
    rstN = 1'b1;
    idleGap(3);

    // fill with ones: zeros for N periods, then ones
    for (int i = 0; i < TOTAL + 10; i++) doStep(1'b1, 1);

    // alternating pattern back to back
    for (int i = 0; i < 2 * TOTAL; i++) doStep(1'(i & 1), 1);

    // random data with random idle gaps
    for (int i = 0; i < 300; i++) begin
      doStep(1'($urandom), 1);
      if ($urandom_range(0, 3) == 0) idleGap(int'($urandom_range(1, 6)));
    end

    // enable held through whole periods, mixed with short ones
    for (int i = 0; i < 60; i++) begin
      doStep(1'($urandom), ((i % 3) == 0) ? 3 : 1);
    end

    // single lone one among zeros, traced through the full delay
    doStep(1'b1, 1);
    for (int i = 0; i < TOTAL + 2; i++) doStep(1'b0, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

endmodule